// File: doc/BRIEF.md
# DS3 Transmit Overhead Override Port

This block sits in the serial DS3 transmit path and lets outside logic take over any overhead bit of the frame. Each clock carries one line bit. With each bit comes a slot-type code that says whether the bit is payload or which overhead bit it is. A neighbour block also supplies the overhead value it generated for that slot. For P slots, this value is the parity the neighbour computed over the payload.

The block raises an overhead clock pulse for every overhead slot, and a start-of-frame marker on the pulse for the first slot of the frame (X1). During that pulse, outside logic answers with an override bit and an override enable. On an enabled X, F, M or C slot, the override bit replaces the internal value. On an enabled P slot, the override bit acts as an error mask: it is XORed onto the computed parity. Without the enable, the internal value goes out. Payload bits pass through untouched.

A DS3 frame has 56 overhead slots, one leading each 85-bit block. Slot sequencing and the parity itself are produced upstream.

Top module: `ds3_ovr_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_bit`, `oh_clk` and `oh_sof` are 0.
- R2: `oh_clk` is high in the cycle after an overhead slot code (1 = X, 2 = P, 3 = M, 4 = F, 5 = C) is presented on `tx_slot`. It is low in the cycle after a payload code (0) is presented.
- R3: `oh_sof` is high in the cycle after an overhead slot presented with `tx_frame_start` high. It is otherwise low, and never high while `oh_clk` is low.
- R4: A payload bit presented in cycle n appears unchanged on `out_bit` in cycle n+2. This holds whatever `ovr_bit` and `ovr_en` carry in cycle n+1.
- R5: For an X, M, F or C slot presented in cycle n, if `ovr_en` is high in cycle n+1, then `out_bit` in cycle n+2 equals `ovr_bit` from cycle n+1.
- R6: For a P slot presented in cycle n, if `ovr_en` is high in cycle n+1, then `out_bit` in cycle n+2 equals `tx_int_oh` from cycle n XOR `ovr_bit` from cycle n+1.
- R7: For any overhead slot presented in cycle n, if `ovr_en` is low in cycle n+1, then `out_bit` in cycle n+2 equals `tx_int_oh` from cycle n, and `ovr_bit` has no effect.
- R8: Slot codes 6 and 7 are handled as payload. They raise no `oh_clk` and pass the data bit through as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit | input | 1 | Incoming serial line bit |
| tx_slot | input | 3 | Slot type of `tx_bit` (0 payload, 1 X, 2 P, 3 M, 4 F, 5 C) |
| tx_frame_start | input | 1 | High on the first overhead slot of a frame |
| tx_int_oh | input | 1 | Internally generated overhead value (computed parity on P slots) |
| ovr_bit | input | 1 | External overhead bit, sampled while `oh_clk` is high |
| ovr_en | input | 1 | External override enable, sampled while `oh_clk` is high |
| oh_clk | output | 1 | One-cycle pulse per overhead slot |
| oh_sof | output | 1 | Start-of-frame marker on the X1 pulse |
| out_bit | output | 1 | Merged transmit stream |

## Verification
`oh_clk` and `oh_sof` answer a slot code one cycle after it is presented. The override pair is taken in that same pulse cycle. The merged bit reaches `out_bit` two cycles after the slot was presented.

The bench drives and samples on the falling edge using a skewed loop. In each loop step it checks the output of the item presented two steps earlier, checks the pulse for the item presented one step earlier and supplies that item's override pair, then presents a new item. Override pairs are also driven during payload cycles, so the bench can see that they are ignored there.

// File: rtl/ds3_ovr_pkg.sv
package ds3_ovr_pkg;
  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SLOT_PAY = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_X   = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_P   = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_M   = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_F   = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_C   = 3'd5;

  // overhead slot: any defined non-payload code
  function automatic logic slot_is_oh(input logic [SLOT_W-1:0] s);
    return (s >= SLOT_X) && (s <= SLOT_C);
  endfunction

  function automatic logic slot_is_par(input logic [SLOT_W-1:0] s);
    return s == SLOT_P;
  endfunction

  // merge rule: replace, mask parity, or pass through
  function automatic logic merge_bit(input logic oh, input logic par,
                                     input logic dat, input logic intv,
                                     input logic en, input logic ext);
    logic r;
    if (!oh)      r = dat;
    else if (!en) r = intv;
    else if (par) r = intv ^ ext;
    else          r = ext;
    return r;
  endfunction
endpackage

// File: rtl/ds3_ovr_capture.sv
module ds3_ovr_capture
  import ds3_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_bit,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic              in_fs,
  input  logic              in_int,
  output logic              cap_bit,
  output logic              cap_int,
  output logic              cap_oh,
  output logic              cap_par,
  output logic              cap_sof
);
  logic slot_oh_w;
  logic slot_par_w;

  assign slot_oh_w  = slot_is_oh(in_slot);
  assign slot_par_w = slot_is_par(in_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_bit <= 1'b0;
      cap_int <= 1'b0;
      cap_oh  <= 1'b0;
      cap_par <= 1'b0;
      cap_sof <= 1'b0;
    end else begin
      cap_bit <= in_bit;
      cap_int <= in_int;
      cap_oh  <= slot_oh_w;
      cap_par <= slot_par_w;
      cap_sof <= slot_oh_w & in_fs;
    end
  end

  AST_PULSE_ON_OH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) |=> cap_oh); // R2
  AST_NO_PULSE_ON_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot inside {3'd0, 3'd6, 3'd7}) |=> !cap_oh); // R8
  AST_SOF_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sof |-> cap_oh); // R3
endmodule

// File: rtl/ds3_ovr_merge.sv
module ds3_ovr_merge
  import ds3_ovr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_bit,
  input  logic cap_int,
  input  logic cap_oh,
  input  logic cap_par,
  input  logic ext_bit,
  input  logic ext_en,
  output logic mrg_bit
);
  logic nxt_bit;

  assign nxt_bit = merge_bit(cap_oh, cap_par, cap_bit, cap_int, ext_en, ext_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) mrg_bit <= 1'b0;
    else        mrg_bit <= nxt_bit;
  end

  AST_PAYLOAD_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_oh |=> (mrg_bit == $past(cap_bit))); // R4
  AST_EXT_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_oh && !cap_par && ext_en) |=> (mrg_bit == $past(ext_bit))); // R5
  AST_PAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_oh && cap_par && ext_en) |=> (mrg_bit != ($past(cap_int) ^ ~$past(ext_bit)))); // R6
  AST_INTERNAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_oh && !ext_en) |=> (mrg_bit == $past(cap_int))); // R7
endmodule

// File: rtl/ds3_ovr_port.sv
module ds3_ovr_port
  import ds3_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bit,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic              tx_frame_start,
  input  logic              tx_int_oh,
  input  logic              ovr_bit,
  input  logic              ovr_en,
  output logic              oh_clk,
  output logic              oh_sof,
  output logic              out_bit
);
  logic cap_bit_w;
  logic cap_int_w;
  logic cap_oh_w;
  logic cap_par_w;
  logic cap_sof_w;

  ds3_ovr_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_bit  (tx_bit),
    .in_slot (tx_slot),
    .in_fs   (tx_frame_start),
    .in_int  (tx_int_oh),
    .cap_bit (cap_bit_w),
    .cap_int (cap_int_w),
    .cap_oh  (cap_oh_w),
    .cap_par (cap_par_w),
    .cap_sof (cap_sof_w)
  );

  ds3_ovr_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_bit (cap_bit_w),
    .cap_int (cap_int_w),
    .cap_oh  (cap_oh_w),
    .cap_par (cap_par_w),
    .ext_bit (ovr_bit),
    .ext_en  (ovr_en),
    .mrg_bit (out_bit)
  );

  assign oh_clk = cap_oh_w;
  assign oh_sof = cap_sof_w;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!oh_clk && !oh_sof && !out_bit)); // R1
endmodule

// File: tb/ds3_ovr_port_tb.sv
module ds3_ovr_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b0;
  logic [2:0] tx_slot = 3'd0;
  logic       tx_frame_start = 1'b0;
  logic       tx_int_oh = 1'b0;
  logic       ovr_bit = 1'b0;
  logic       ovr_en = 1'b0;
  logic       oh_clk;
  logic       oh_sof;
  logic       out_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2:0] a_slot [64];
  logic       a_bit  [64];
  logic       a_int  [64];
  logic       a_fs   [64];
  logic       a_eb   [64];
  logic       a_ee   [64];

  always #2.5 clk = ~clk;

  ds3_ovr_port u_dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_slot(tx_slot),
    .tx_frame_start(tx_frame_start), .tx_int_oh(tx_int_oh),
    .ovr_bit(ovr_bit), .ovr_en(ovr_en),
    .oh_clk(oh_clk), .oh_sof(oh_sof), .out_bit(out_bit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit is_ohc(input logic [2:0] s);
    return s == 3'd1 || s == 3'd2 || s == 3'd3 || s == 3'd4 || s == 3'd5;
  endfunction

  // run n items through the pipeline with a skew of one step per stage
  task automatic run(input int n);
    for (int k = 0; k < n + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        automatic int i = k - 2;
        automatic logic e;
        automatic string tag;
        if (!is_ohc(a_slot[i])) begin
          e = a_bit[i];
          tag = (a_slot[i] > 3'd5) ? "R8" : "R4";
        end else if (!a_ee[i]) begin
          e = a_int[i]; tag = "R7";
        end else if (a_slot[i] == 3'd2) begin
          e = a_int[i] ^ a_eb[i]; tag = "R6";
        end else begin
          e = a_eb[i]; tag = "R5";
        end
        check(tag, out_bit, e);
      end
      if (k >= 1 && k - 1 < n) begin
        automatic int j = k - 1;
        check(a_slot[j] > 3'd5 ? "R8" : "R2", oh_clk, is_ohc(a_slot[j]));
        check("R3", oh_sof, is_ohc(a_slot[j]) && a_fs[j]);
        ovr_bit = a_eb[j];
        ovr_en  = a_ee[j];
      end else begin
        ovr_bit = 1'b1; ovr_en = 1'b1;
      end
      if (k < n) begin
        tx_bit = a_bit[k]; tx_slot = a_slot[k];
        tx_frame_start = a_fs[k]; tx_int_oh = a_int[k];
      end else begin
        tx_bit = 1'b0; tx_slot = 3'd0; tx_frame_start = 1'b0; tx_int_oh = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tx_bit = 1'b1; tx_slot = 3'd1; tx_frame_start = 1'b1; tx_int_oh = 1'b1;
    ovr_bit = 1'b1; ovr_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", oh_clk, 1'b0);
    check("R1", oh_sof, 1'b0);
    check("R1", out_bit, 1'b0);
    tx_bit = 1'b0; tx_slot = 3'd0; tx_frame_start = 1'b0; tx_int_oh = 1'b0;
    ovr_bit = 1'b0; ovr_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", oh_clk, 1'b0);
    check("R1", out_bit, 1'b0);
  endtask

  // R4: payload with override pairs active in every pulse slot
  task automatic t_payload();
    for (int i = 0; i < 40; i++) begin
      a_slot[i] = 3'd0; a_bit[i] = 1'($urandom); a_int[i] = ~a_bit[i];
      a_fs[i] = 1'($urandom); a_eb[i] = ~a_bit[i]; a_ee[i] = 1'b1;
    end
    run(40);
  endtask

  // R5/R6: every overhead type overridden
  task automatic t_override();
    for (int i = 0; i < 40; i++) begin
      a_slot[i] = 3'(1 + (i % 5)); a_bit[i] = 1'($urandom);
      a_int[i] = 1'($urandom); a_fs[i] = 1'b0;
      a_eb[i] = 1'($urandom); a_ee[i] = 1'b1;
    end
    run(40);
  endtask

  // R6: all four mask/parity combinations on P slots
  task automatic t_pmask();
    for (int i = 0; i < 8; i++) begin
      a_slot[i] = 3'd2; a_bit[i] = 1'b0;
      a_int[i] = 1'(i >> 1); a_eb[i] = 1'(i); a_ee[i] = 1'b1; a_fs[i] = 1'b0;
    end
    run(8);
  endtask

  // R7: override disabled, external bit opposite to internal
  task automatic t_internal();
    for (int i = 0; i < 30; i++) begin
      a_slot[i] = 3'(1 + (i % 5)); a_bit[i] = 1'($urandom);
      a_int[i] = 1'($urandom); a_eb[i] = ~a_int[i]; a_ee[i] = 1'b0; a_fs[i] = 1'b0;
    end
    run(30);
  endtask

  // R3/R8: frame-like mix, start marker on first slot, reserved codes
  task automatic t_frame();
    for (int i = 0; i < 60; i++) begin
      if (i % 6 == 0) a_slot[i] = 3'(1 + ((i / 6) % 5));
      else if (i % 6 == 3) a_slot[i] = 3'(6 + (i % 2));
      else a_slot[i] = 3'd0;
      a_bit[i] = 1'($urandom); a_int[i] = 1'($urandom);
      a_fs[i] = (i == 0) || (i == 3) || (i == 4);
      a_eb[i] = 1'($urandom); a_ee[i] = 1'($urandom);
    end
    run(60);
  endtask

  initial begin
    t_reset();
    t_payload();
    t_override();
    t_pmask();
    t_internal();
    t_frame();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule